// File: doc/BRIEF.md
# RGMII Receive Re-timing Sampler

This block sits between the five RGMII receive pads (the receive control line and four data lines) and the MAC. It samples those inputs with a fast timing-adjustment clock instead of capturing them directly on RX_CLK edges. The block samples RX_CLK itself in the timing-adjustment domain. Each RX_CLK edge it sees, rising or falling, clears a small counter. Each input is captured once, when that counter reaches a programmable sample count. The captured values are sorted into a rising-half group and a falling-half group and handed over as one DDR pair per RX_CLK period.

Four configuration inputs set the sample point. `cfg_enable` switches the re-timing on. When it is off, the inputs are taken at the first count after the edge. `cfg_setup` selects a fixed automatic sample count that gives a nominal 2 ns delay. The other two inputs apply only when re-timing is on and automatic mode is off: `cfg_delay` gives the sample count, and `cfg_skew` adds a per-input trim for lines that arrive late. The skew trim is a whole number of extra timing-adjustment cycles.

Configuration is taken only at rising RX_CLK edges. The design has a single clock: RX_CLK is treated as data.

Top module: `rgmii_rx_retimer`

## Requirements
- R1: After reset, all eight DDR data outputs and `pair_valid` are 0, and the held configuration is the bypass setting.
- R2: Each RX_CLK level change is detected through a two-flop synchronizer. Count k means the input level present at the k-th rising edge of `clk_adj`, counting from 0 at the first `clk_adj` edge that samples the new RX_CLK level. Every input is captured at count k equal to its target.
- R3: With `cfg_enable`=1 and `cfg_setup`=0, the target of an input whose skew bit is clear is `cfg_delay`, for any value from 0 to 31.
- R4: Skew bit positions are: bit 0 for the control line, bit 1 for RXD[3], bit 2 for RXD[2], bit 3 for RXD[1] and bit 4 for RXD[0]. In manual mode a set bit adds SKEW_STEP (default 1) cycles to that input's target.
- R5: With `cfg_enable`=0, every target is 0, and `cfg_setup`, `cfg_delay` and `cfg_skew` have no effect on the outputs.
- R6: With `cfg_enable`=1 and `cfg_setup`=1, every target is AUTO_DLY (default 1), and `cfg_delay` and `cfg_skew` have no effect.
- R7: Values captured after a rising RX_CLK edge appear on `rise_ctl`/`rise_rxd`. Values captured after a falling edge appear on `fall_ctl`/`fall_rxd`.
- R8: `pair_valid` pulses for exactly one cycle per RX_CLK period, when the last input of the falling half is captured. The data outputs change only in that cycle.
- R9: The counter saturates and does not wrap. While RX_CLK stalls, no input is captured a second time.
- R10: The configuration inputs are latched only at a rising RX_CLK edge. A change made in the middle of a period does not affect that period's falling half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_adj | input | 1 | Timing-adjustment clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk_in | input | 1 | Receive clock from the pad, treated as data |
| rx_ctl_in | input | 1 | Receive control pad |
| rxd_in | input | 4 | Receive data pads |
| cfg_enable | input | 1 | Re-timing enable (0 = bypass) |
| cfg_setup | input | 1 | Automatic sample count select |
| cfg_delay | input | DLY_W | Manual sample count |
| cfg_skew | input | 5 | Per-input trim bits |
| rise_ctl | output | 1 | Control bit of the rising half |
| rise_rxd | output | 4 | Data nibble of the rising half |
| fall_ctl | output | 1 | Control bit of the falling half |
| fall_rxd | output | 4 | Data nibble of the falling half |
| pair_valid | output | 1 | One-cycle strobe: a new DDR pair is present |

## Verification
The bench sweeps the manual delay over its full range. Each input changes value exactly at the target count in one half and one count after it in the other, so a sample taken one cycle early or late reads the wrong value. Each skew bit is set alone to catch a swapped lane order, which would trim the wrong line. Bypass and automatic modes are run with junk in the fields they must ignore; a design that leaked those fields would move the sample point. A stalled RX_CLK with a late data change shows whether a counter that wraps takes a second sample. A configuration change in the middle of a period shows whether the falling half was sampled with mixed settings.

// File: rtl/rgrt_pkg.sv
package rgrt_pkg;

   // number of sampled receive inputs: control plus four data bits
   localparam int unsigned RGRT_LANES = 5;

   typedef enum logic [1:0] {
      RGRT_BYPASS = 2'd0,
      RGRT_MANUAL = 2'd1,
      RGRT_AUTO   = 2'd2
   } rgrt_mode_e;

   function automatic rgrt_mode_e rgrt_mode(input logic en, input logic setup);
      if (!en)        return RGRT_BYPASS;
      else if (setup) return RGRT_AUTO;
      else            return RGRT_MANUAL;
   endfunction

endpackage

// File: rtl/rgrt_front.sv
module rgrt_front #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LANES       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_clk_pad,
   input  logic [LANES-1:0] lanes_pad,
   output logic [LANES-1:0] lanes_al,
   output logic             edge_pulse,
   output logic             edge_rise
);
   // one extra stage past the synchronizer holds the previous level for the compare
   logic [SYNC_STAGES:0]   clk_sh;
   logic [LANES-1:0]       dpipe [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_sh <= '0;
      else        clk_sh <= {clk_sh[SYNC_STAGES-1:0], rx_clk_pad};
   end

   // data follows the same number of stages so it stays aligned with the edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(SYNC_STAGES); i++) dpipe[i] <= '0;
      end else begin
         dpipe[0] <= lanes_pad;
         for (int i = 1; i < int'(SYNC_STAGES); i++) dpipe[i] <= dpipe[i-1];
      end
   end

   assign lanes_al   = dpipe[SYNC_STAGES-1];
   assign edge_pulse = clk_sh[SYNC_STAGES-1] ^ clk_sh[SYNC_STAGES];
   assign edge_rise  = edge_pulse & clk_sh[SYNC_STAGES-1];
endmodule

// File: rtl/rgrt_timer.sv
module rgrt_timer #(
   parameter int unsigned CNT_W   = 6,
   parameter int unsigned CNT_MAX = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_pulse,
   output logic [CNT_W-1:0] cur_cnt
);
   logic [CNT_W-1:0] cnt_q;

   // the count seen in the edge cycle is already zero
   assign cur_cnt = edge_pulse ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= CNT_W'(CNT_MAX);
      else if (cur_cnt == CNT_W'(CNT_MAX)) cnt_q <= cur_cnt;
      else                               cnt_q <= cur_cnt + 1'b1;
   end
endmodule

// File: rtl/rgrt_lane.sv
module rgrt_lane #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_pulse,
   input  logic [CNT_W-1:0] cur_cnt,
   input  logic [CNT_W-1:0] tgt,
   output logic             cap,
   output logic             done_n
);
   logic done_q;

   // one capture per half: the done flag re-arms only on an edge
   assign cap    = (cur_cnt == tgt) && (edge_pulse || !done_q);
   assign done_n = edge_pulse ? cap : (done_q | cap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b1;
      else        done_q <= done_n;
   end
endmodule

// File: rtl/rgmii_rx_retimer.sv
module rgmii_rx_retimer
   import rgrt_pkg::*;
#(
   parameter int unsigned DLY_W       = 5,
   parameter int unsigned SKEW_STEP   = 1,
   parameter int unsigned AUTO_DLY    = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_adj,
   input  logic             rst_n,
   input  logic             rx_clk_in,
   input  logic             rx_ctl_in,
   input  logic [3:0]       rxd_in,
   input  logic             cfg_enable,
   input  logic             cfg_setup,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic [4:0]       cfg_skew,
   output logic             rise_ctl,
   output logic [3:0]       rise_rxd,
   output logic             fall_ctl,
   output logic [3:0]       fall_rxd,
   output logic             pair_valid
);
   localparam int unsigned LANES   = RGRT_LANES;
   localparam int unsigned CNT_MAX = (2 ** DLY_W) - 1 + SKEW_STEP;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AUTO_DLY > CNT_MAX) begin : g_bad_auto
      $error("AUTO_DLY exceeds the counter range");
   end

   typedef struct packed {
      logic             en;
      logic             setup;
      logic [DLY_W-1:0] dly;
      logic [LANES-1:0] skew;
   } cfg_t;

   // lane order follows the skew bits: 0 ctl, 1 rxd[3], ... 4 rxd[0]
   logic [LANES-1:0] lanes_pad, lanes_al;
   assign lanes_pad = {rxd_in[0], rxd_in[1], rxd_in[2], rxd_in[3], rx_ctl_in};

   logic             edge_pulse, edge_rise;
   logic [CNT_W-1:0] cur_cnt;

   rgrt_front #(.SYNC_STAGES(SYNC_STAGES), .LANES(LANES)) u_front (
      .clk(clk_adj), .rst_n(rst_n), .rx_clk_pad(rx_clk_in), .lanes_pad(lanes_pad),
      .lanes_al(lanes_al), .edge_pulse(edge_pulse), .edge_rise(edge_rise)
   );

   rgrt_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_timer (
      .clk(clk_adj), .rst_n(rst_n), .edge_pulse(edge_pulse), .cur_cnt(cur_cnt)
   );

   // configuration is held from one rising RX_CLK edge to the next
   cfg_t cfg_in, cfg_q, cfg_use;
   assign cfg_in  = '{en: cfg_enable, setup: cfg_setup, dly: cfg_delay, skew: cfg_skew};
   assign cfg_use = edge_rise ? cfg_in : cfg_q;

   always_ff @(posedge clk_adj or negedge rst_n) begin
      if (!rst_n)         cfg_q <= '0;
      else if (edge_rise) cfg_q <= cfg_in;
   end

   logic pol_q, pol_use;
   assign pol_use = edge_pulse ? edge_rise : pol_q;

   always_ff @(posedge clk_adj or negedge rst_n) begin
      if (!rst_n) pol_q <= 1'b0;
      else        pol_q <= pol_use;
   end

   rgrt_mode_e       mode;
   logic [LANES-1:0] cap, done_n;
   logic [CNT_W-1:0] tgt [LANES];
   assign mode = rgrt_mode(cfg_use.en, cfg_use.setup);

   for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      logic [CNT_W-1:0] trim;
      if (SKEW_STEP == 0) begin : g_no_trim
         assign trim = '0;
      end else begin : g_trim
         assign trim = cfg_use.skew[g] ? CNT_W'(SKEW_STEP) : '0;
      end

      always_comb begin
         unique case (mode)
            RGRT_MANUAL: tgt[g] = CNT_W'(cfg_use.dly) + trim;
            RGRT_AUTO:   tgt[g] = CNT_W'(AUTO_DLY);
            default:     tgt[g] = '0;
         endcase
      end

      rgrt_lane #(.CNT_W(CNT_W)) u_lane (
         .clk(clk_adj), .rst_n(rst_n), .edge_pulse(edge_pulse), .cur_cnt(cur_cnt),
         .tgt(tgt[g]), .cap(cap[g]), .done_n(done_n[g])
      );
   end

   // per-half staging, then a pair hand-off at the end of the falling half
   logic [LANES-1:0] rise_stg, fall_stg, rise_stg_n, fall_stg_n;
   logic [LANES-1:0] rise_out, fall_out;
   logic             have_rise, half_done, emit;

   always_comb begin
      rise_stg_n = rise_stg;
      fall_stg_n = fall_stg;
      for (int i = 0; i < int'(LANES); i++) begin
         if (cap[i] && pol_use)  rise_stg_n[i] = lanes_al[i];
         if (cap[i] && !pol_use) fall_stg_n[i] = lanes_al[i];
      end
   end

   assign half_done = (|cap) && (&done_n);
   assign emit      = half_done && !pol_use && have_rise;

   always_ff @(posedge clk_adj or negedge rst_n) begin
      if (!rst_n) begin
         rise_stg   <= '0;
         fall_stg   <= '0;
         rise_out   <= '0;
         fall_out   <= '0;
         have_rise  <= 1'b0;
         pair_valid <= 1'b0;
      end else begin
         rise_stg   <= rise_stg_n;
         fall_stg   <= fall_stg_n;
         pair_valid <= emit;
         if (emit) begin
            rise_out <= rise_stg_n;
            fall_out <= fall_stg_n;
         end
         if (half_done && pol_use)                    have_rise <= 1'b1;
         else if (edge_rise || (half_done && !pol_use)) have_rise <= 1'b0;
      end
   end

   assign rise_ctl = rise_out[0];
   assign rise_rxd = {rise_out[1], rise_out[2], rise_out[3], rise_out[4]};
   assign fall_ctl = fall_out[0];
   assign fall_rxd = {fall_out[1], fall_out[2], fall_out[3], fall_out[4]};
endmodule

// File: rtl/rgmii_rx_retimer_chk.sv
module rgmii_rx_retimer_chk #(
   parameter int unsigned CNT_W   = 6,
   parameter int unsigned CNT_MAX = 32,
   parameter int unsigned CFG_W   = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             edge_pulse,
   input logic             edge_rise,
   input logic [CNT_W-1:0] cur_cnt,
   input logic [CFG_W-1:0] cfg_q,
   input logic             pair_valid,
   input logic [9:0]       dout
);
   // R2: a detected edge restarts the count from zero
   assert_edge_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> (edge_pulse || cur_cnt == CNT_W'(1)));

   // R9: once saturated the count stays put until the next edge
   assert_count_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_cnt == CNT_W'(CNT_MAX)) |=> (edge_pulse || cur_cnt == CNT_W'(CNT_MAX)));

   // R10: held configuration moves only at a rising RX_CLK edge
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_rise |=> $stable(cfg_q));

   // R8: the pair strobe is a single-cycle pulse
   assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid);

   // R8: data outputs change only together with the strobe
   assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_valid |-> $stable(dout));
endmodule

bind rgmii_rx_retimer rgmii_rx_retimer_chk #(
   .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .CFG_W($bits(cfg_t))
) u_chk (
   .clk(clk_adj), .rst_n(rst_n), .edge_pulse(edge_pulse), .edge_rise(edge_rise),
   .cur_cnt(cur_cnt), .cfg_q(cfg_q), .pair_valid(pair_valid),
   .dout({rise_ctl, rise_rxd, fall_ctl, fall_rxd})
);

// File: tb/rgmii_rx_retimer_tb.sv
`timescale 1ns/1ps
module rgmii_rx_retimer_tb;
   localparam int AUTO = 1;
   localparam int HALF = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_clk = 1'b0, rx_ctl = 1'b0;
   logic [3:0] rxd = '0;
   logic       c_en = 1'b0, c_setup = 1'b0;
   logic [4:0] c_dly = '0, c_skew = '0;
   logic       rise_ctl, fall_ctl, pair_valid;
   logic [3:0] rise_rxd, fall_rxd;

   int checks = 0, errors = 0, vcnt = 0;

   always #4 clk = ~clk;

   rgmii_rx_retimer u_dut (
      .clk_adj(clk), .rst_n(rst_n), .rx_clk_in(rx_clk), .rx_ctl_in(rx_ctl), .rxd_in(rxd),
      .cfg_enable(c_en), .cfg_setup(c_setup), .cfg_delay(c_dly), .cfg_skew(c_skew),
      .rise_ctl(rise_ctl), .rise_rxd(rise_rxd), .fall_ctl(fall_ctl), .fall_rxd(fall_rxd),
      .pair_valid(pair_valid)
   );

   always @(negedge clk) if (pair_valid) vcnt++;

   // lane vector: bit0 ctl, bit1 rxd[3], bit2 rxd[2], bit3 rxd[1], bit4 rxd[0]
   task automatic put(input logic [4:0] v);
      rx_ctl = v[0];
      rxd    = {v[1], v[2], v[3], v[4]};
   endtask

   function automatic logic [4:0] got_rise();
      return {rise_rxd[0], rise_rxd[1], rise_rxd[2], rise_rxd[3], rise_ctl};
   endfunction
   function automatic logic [4:0] got_fall();
      return {fall_rxd[0], fall_rxd[1], fall_rxd[2], fall_rxd[3], fall_ctl};
   endfunction

   function automatic int tgt_of(input int i, input logic en, input logic st,
                                 input logic [4:0] d, input logic [4:0] sk);
      if (!en)    return 0;
      else if (st) return AUTO;
      else        return int'(d) + int'(sk[i]);
   endfunction

   function automatic logic [4:0] expect_v(input logic [4:0] a, input logic [4:0] b, input int t,
                                           input logic en, input logic st,
                                           input logic [4:0] d, input logic [4:0] sk);
      logic [4:0] r;
      for (int i = 0; i < 5; i++) r[i] = (tgt_of(i, en, st, d, sk) < t) ? a[i] : b[i];
      return r;
   endfunction

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one half: level lvl, lanes a from count 0 to t-1, then b; lasts len cycles
   task automatic half(input logic lvl, input logic [4:0] a, input logic [4:0] b,
                       input int t, input int len, input bit chg,
                       input logic [4:0] nd);
      rx_clk = lvl;
      put(a);
      for (int k = 0; k < len; k++) begin
         if (k == t) put(b);
         @(negedge clk);
         if (chg && k == 5) c_dly = nd;
      end
      if (t >= len) put(b);
   endtask

   task automatic period(input string req, input logic [4:0] ar, input logic [4:0] br, input int tr,
                         input int rlen, input logic [4:0] af, input logic [4:0] bf,
                         input int tf, input bit chg, input logic [4:0] nd);
      logic [4:0] er, ef;
      logic en0 = c_en, st0 = c_setup;
      logic [4:0] d0 = c_dly, s0 = c_skew;
      er = expect_v(ar, br, tr, en0, st0, d0, s0);
      ef = expect_v(af, bf, tf, en0, st0, d0, s0);
      vcnt = 0;
      half(1'b1, ar, br, tr, rlen, chg, nd);
      half(1'b0, af, bf, tf, HALF, 1'b0, 5'd0);
      check({req, " R7 rise"}, {5'd0, got_rise()}, {5'd0, er});
      check({req, " R7 fall"}, {5'd0, got_fall()}, {5'd0, ef});
      check("R8 one strobe per period", 10'(vcnt), 10'd1);
   endtask

   task automatic set_cfg(input logic en, input logic st, input logic [4:0] d, input logic [4:0] sk);
      c_en = en; c_setup = st; c_dly = d; c_skew = sk;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset outputs", {got_rise(), got_fall()}, 10'd0);
      check("R1 reset strobe", {9'd0, pair_valid}, 10'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R3: manual delay sweep, change exactly at and one after the target
      set_cfg(1'b1, 1'b0, 5'd0, 5'd0);
      period("R3 prime", 5'h0a, 5'h15, 1, HALF, 5'h03, 5'h1c, 0, 1'b0, 5'd0);
      for (int d = 0; d < 32; d++) begin
         logic [4:0] a = 5'(d * 7 + 3);
         set_cfg(1'b1, 1'b0, 5'(d), 5'd0);
         period("R2 R3 delay sweep", a, ~a, d + 1, HALF, ~a, a, d, 1'b0, 5'd0);
      end

      // R4: each skew bit alone and all together
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 3; j++) begin
            int d = (j == 0) ? 0 : (j == 1) ? 6 : 31;
            logic [4:0] sk = (i == 5) ? 5'h1f : 5'(1 << i);
            set_cfg(1'b1, 1'b0, 5'(d), sk);
            period("R4 skew", 5'h13, 5'h0c, d + 1, HALF, 5'h06, 5'h19, d + 1, 1'b0, 5'd0);
         end
      end

      // R5: bypass ignores setup, delay and skew
      set_cfg(1'b0, 1'b1, 5'd17, 5'h1f);
      period("R5 bypass", 5'h1b, 5'h04, 1, HALF, 5'h0e, 5'h11, 1, 1'b0, 5'd0);
      check("R5 bypass rise value", {5'd0, got_rise()}, {5'd0, 5'h1b});

      // R6: automatic count ignores delay and skew
      set_cfg(1'b1, 1'b1, 5'd9, 5'h1f);
      period("R6 auto", 5'h1b, 5'h04, AUTO, HALF, 5'h0e, 5'h11, AUTO + 1, 1'b0, 5'd0);
      check("R6 auto values", {got_rise(), got_fall()}, {5'h04, 5'h0e});

      // R10: mid-period delay change must not reach this falling half
      set_cfg(1'b1, 1'b0, 5'd3, 5'd0);
      period("R10 mid change", 5'h01, 5'h1e, 4, HALF, 5'h07, 5'h18, 4, 1'b1, 5'd20);
      check("R10 old delay kept", {5'd0, got_fall()}, {5'd0, 5'h07});
      period("R10 new delay", 5'h02, 5'h1d, 21, HALF, 5'h08, 5'h17, 20, 1'b0, 5'd0);

      // R9: stalled RX_CLK, data changes long after the sample point
      set_cfg(1'b1, 1'b0, 5'd2, 5'd0);
      period("R9 stall", 5'h15, 5'h0a, 100, 200, 5'h09, 5'h16, 3, 1'b0, 5'd0);
      check("R9 no resample", {5'd0, got_rise()}, {5'd0, 5'h15});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule